// File: doc/BRIEF.md
# Disk Bit-Stream DMA Controller

This block moves 16-bit words between a serial disk bit stream and system memory. In the read direction it shifts incoming bits into a 16-bit window. It watches that window for a programmable sync pattern, assembles bytes and words, and issues one memory write per completed word. In the write direction it fetches words from memory and hands them out one bit at a time, most significant bit first, whenever the disk serialiser asks for a bit.

Software programs a word-aligned memory pointer, a sync pattern and a mode word. It then starts a transfer by writing the length register twice in a row with the enable bit set. A single enabling write only arms the controller, so a stray write cannot start a transfer. A length write with the enable bit clear aborts any transfer at once.

A status word reports:
- the last assembled byte and a byte-ready flag that is cleared on read,
- whether a transfer is running and in which direction,
- a sync-seen flag that is held for a few bit times.

Two single-cycle interrupt pulses mark each sync match and the completion of a transfer.

Top module: `diskDma`

## Requirements
- R1: After reset the status word reads 0x0000, the pointer reads 0, no memory request, serial output or interrupt is active, and the sync register holds 0x4489.
- R2: A pointer write stores the value with bit 0 forced to 0. Each transferred word adds 2 to the pointer, which reads back at register address 0.
- R3: A length write (address 1) with bit 15 set only arms the controller. Only the next length write with bit 15 set starts a transfer, and bit 14 of that second write selects the direction (0 disk-to-memory, 1 memory-to-disk). A length write with bit 15 clear disarms the controller.
- R4: A length write with bit 15 clear stops any running transfer in the next cycle and drops the memory request. Further disk bits produce no memory writes.
- R5: When sync waiting is off, word boundaries are counted from the start of a read transfer. Each group of 16 bits, first bit in the most significant position, is written to memory at the pointer.
- R6: When mode register (address 3) bit 10 is set, a read transfer stores nothing until the stream matches the sync register (address 2). It stores from the 16 bits that follow the match.
- R7: `irqSync` pulses for one cycle after every bit that completes a sync match, whether or not a transfer is running and whatever the mode.
- R8: A read transfer writes exactly the word count from length bits 13:0, including the last word. It then pulses `irqBlock` once and returns to idle.
- R9: A write transfer fetches the programmed number of words at successive pointer addresses and shifts each out most significant bit first, one bit per `diskBitReq`. It pulses `irqBlock` after the last bit of the last word.
- R10: Status (address 4) bit 15 sets each time 8 more bits complete, counted from the last sync match or transfer start. Bits 7:0 then hold that byte. A status read clears bit 15, except when the read falls in the same cycle as a new byte completes.
- R11: Status bit 12 sets on a sync match and stays set for SYNC_HOLD further bit strobes.
- R12: Status bit 14 shows a running transfer. Status bit 13 copies bit 14 of the last length write.
- R13: A starting length write whose count bits are zero starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears byte-ready on status reads) |
| regAddr | input | 3 | Register select: 0 pointer, 1 length, 2 sync, 3 mode, 4 status |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for the selected address |
| dmaReq | output | 1 | Memory request, held until acknowledged |
| dmaWe | output | 1 | 1 = write to memory, 0 = read from memory |
| dmaAddr | output | ADDR_W | Memory byte address |
| dmaWrData | output | 16 | Word to write to memory |
| dmaAck | input | 1 | Memory acknowledge, one cycle |
| dmaRdData | input | 16 | Word read from memory, valid with `dmaAck` |
| diskBitIn | input | 1 | Incoming disk bit |
| diskBitValid | input | 1 | Strobe qualifying `diskBitIn` |
| diskBitOut | output | 1 | Outgoing disk bit |
| diskBitOutValid | output | 1 | `diskBitOut` holds a valid bit |
| diskBitReq | input | 1 | Serialiser takes the current outgoing bit |
| irqSync | output | 1 | One-cycle pulse per sync match |
| irqBlock | output | 1 | One-cycle pulse per completed transfer |

## Verification
Read transfers are fed streams built from alternating, paired and nibble-run words that cannot contain the sync pattern by accident. In sync mode a preamble of such words runs before the pattern itself, which shows that only post-match words reach memory. Bytes are swept through a set of values that each move different bit positions, and the ready flag is read both in an idle cycle and in the very cycle a byte completes. Write transfers use memory contents derived arithmetically from the address, so a wrong pointer step or a bit-order swap gives a different serial stream.

// File: rtl/diskDmaPkg.sv
package diskDmaPkg;
  localparam int WORD_W  = 16;
  localparam int COUNT_W = 14;

  localparam logic [2:0] ADDR_PTR  = 3'd0;
  localparam logic [2:0] ADDR_LEN  = 3'd1;
  localparam logic [2:0] ADDR_SYNC = 3'd2;
  localparam logic [2:0] ADDR_MODE = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;

  localparam int LEN_EN_BIT    = 15;
  localparam int LEN_DIR_BIT   = 14;
  localparam int MODE_SYNC_BIT = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNCWAIT,
    ST_RDRUN,
    ST_WRRUN
  } dmaState_e;

  typedef struct packed {
    logic alignBits;
    logic capture;
    logic advance;
    logic loadOut;
    logic flushOut;
  } ctlStrobe_t;
endpackage

// File: rtl/diskDatapath.sv
module diskDatapath
  import diskDmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_HOLD = 2,
  parameter logic [WORD_W-1:0] SYNC_RESET = 16'h4489
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              dmaActive,
  input  logic [WORD_W-1:0] dmaRdData,
  input  logic              diskBitIn,
  input  logic              diskBitValid,
  input  logic              diskBitReq,
  input  ctlStrobe_t        ctl,
  output logic              syncHit,
  output logic              wordDone,
  output logic              remainZero,
  output logic              remainOne,
  output logic              outEmpty,
  output logic              lastBitOut,
  output logic              modeSync,
  output logic [ADDR_W-1:0] ptr,
  output logic [WORD_W-1:0] wordBuf,
  output logic              diskBitOut,
  output logic              diskBitOutValid
);
  localparam int HOLD_W = $clog2(SYNC_HOLD + 1);
  localparam int BITCNT_W = $clog2(WORD_W);
  localparam int OUTCNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0]   shiftIn, nextShift, syncWord, outShift;
  logic [BITCNT_W-1:0] bitCnt;
  logic [OUTCNT_W-1:0] outCnt;
  logic [HOLD_W-1:0]   holdCnt;
  logic [COUNT_W-1:0]  remain;
  logic [7:0]          byteReg;
  logic                byteReady, byteDone, wrDirBit;
  logic                wrPtr, wrLen, wrSync, wrMode, statRd;

  assign wrPtr  = regWr && (regAddr == ADDR_PTR);
  assign wrLen  = regWr && (regAddr == ADDR_LEN);
  assign wrSync = regWr && (regAddr == ADDR_SYNC);
  assign wrMode = regWr && (regAddr == ADDR_MODE);
  assign statRd = regRd && (regAddr == ADDR_STAT);

  // Incoming stream: window, sync compare, byte/word boundaries
  assign nextShift = {shiftIn[WORD_W-2:0], diskBitIn};
  assign syncHit   = diskBitValid && (nextShift == syncWord);
  assign byteDone  = diskBitValid && !syncHit && (bitCnt[2:0] == 3'd7);
  assign wordDone  = diskBitValid && !syncHit && (bitCnt == BITCNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      bitCnt  <= '0;
    end else begin
      if (diskBitValid) shiftIn <= nextShift;
      if (ctl.alignBits) bitCnt <= '0;
      else if (diskBitValid) bitCnt <= syncHit ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg   <= '0;
      byteReady <= 1'b0;
    end else begin
      if (byteDone) begin
        byteReg   <= nextShift[7:0];
        byteReady <= 1'b1;
      end else if (statRd) begin
        byteReady <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (syncHit) holdCnt <= HOLD_W'(SYNC_HOLD);
    else if (diskBitValid && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordBuf <= '0;
    else if (ctl.capture) wordBuf <= nextShift;
  end

  // Software-visible registers and transfer counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      remain   <= '0;
      syncWord <= SYNC_RESET;
      modeSync <= 1'b0;
      wrDirBit <= 1'b0;
    end else begin
      if (wrPtr) ptr <= ADDR_W'(regWrData) & ~ADDR_W'(1);
      else if (ctl.advance) ptr <= ptr + ADDR_W'(2);

      if (wrLen) begin
        remain   <= regWrData[LEN_EN_BIT] ? regWrData[COUNT_W-1:0] : '0;
        wrDirBit <= regWrData[LEN_DIR_BIT];
      end else if (ctl.advance) begin
        remain <= remain - 1'b1;
      end

      if (wrSync) syncWord <= regWrData;
      if (wrMode) modeSync <= regWrData[MODE_SYNC_BIT];
    end
  end

  assign remainZero = (remain == '0);
  assign remainOne  = (remain == COUNT_W'(1));

  // Outgoing serialiser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outCnt   <= '0;
    end else if (ctl.flushOut) begin
      outCnt <= '0;
    end else if (ctl.loadOut) begin
      outShift <= dmaRdData;
      outCnt   <= OUTCNT_W'(WORD_W);
    end else if (diskBitReq && outCnt != '0) begin
      outShift <= {outShift[WORD_W-2:0], 1'b0};
      outCnt   <= outCnt - 1'b1;
    end
  end

  assign outEmpty        = (outCnt == '0);
  assign lastBitOut      = diskBitReq && (outCnt == OUTCNT_W'(1));
  assign diskBitOut      = outShift[WORD_W-1];
  assign diskBitOutValid = !outEmpty;

  always_comb begin
    case (regAddr)
      ADDR_PTR:  regRdData = WORD_W'(ptr);
      ADDR_STAT: regRdData = {byteReady, dmaActive, wrDirBit, (holdCnt != '0), 4'b0000, byteReg};
      default:   regRdData = '0;
    endcase
  end

  // R2
  ptr_even_chk: assert property (@(posedge clk) disable iff (!rstN) !ptr[0]);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.advance |-> !remainZero);
  // R9
  out_load_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.loadOut |-> outEmpty);
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.capture |-> wordDone);
  // R11
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) && !diskBitValid |=> (holdCnt != '0));
endmodule

// File: rtl/diskControl.sv
module diskControl
  import diskDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lenWr,
  input  logic       lenEn,
  input  logic       lenDir,
  input  logic       lenCntZero,
  input  logic       dmaAck,
  input  logic       syncHit,
  input  logic       wordDone,
  input  logic       remainZero,
  input  logic       remainOne,
  input  logic       outEmpty,
  input  logic       lastBitOut,
  input  logic       modeSync,
  output ctlStrobe_t ctl,
  output logic       dmaReq,
  output logic       dmaWe,
  output logic       dmaActive,
  output logic       irqSync,
  output logic       irqBlock
);
  dmaState_e state;
  logic armed, pending, start, stop, acked;

  assign start = lenWr && lenEn && armed && !lenCntZero;
  assign stop  = lenWr && !lenEn;
  assign acked = pending && dmaAck;

  always_comb begin
    ctl           = '0;
    ctl.alignBits = start;
    ctl.flushOut  = start || stop;
    ctl.advance   = acked && !lenWr;
    ctl.loadOut   = acked && !lenWr && (state == ST_WRRUN);
    ctl.capture   = !lenWr && (state == ST_RDRUN) && wordDone &&
                    (!pending || (dmaAck && !remainOne));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      pending  <= 1'b0;
      irqSync  <= 1'b0;
      irqBlock <= 1'b0;
    end else begin
      irqSync  <= syncHit;
      irqBlock <= 1'b0;
      if (stop) begin
        state   <= ST_IDLE;
        armed   <= 1'b0;
        pending <= 1'b0;
      end else if (lenWr && lenEn) begin
        if (armed) begin
          armed <= 1'b0;
          if (!lenCntZero) begin
            pending <= 1'b0;
            if (lenDir) state <= ST_WRRUN;
            else        state <= modeSync ? ST_SYNCWAIT : ST_RDRUN;
          end
        end else begin
          armed <= 1'b1;
        end
      end else begin
        case (state)
          ST_SYNCWAIT: if (syncHit) state <= ST_RDRUN;
          ST_RDRUN: begin
            if (acked && remainOne) begin
              state    <= ST_IDLE;
              pending  <= 1'b0;
              irqBlock <= 1'b1;
            end else if (acked) begin
              pending <= ctl.capture;
            end else if (ctl.capture) begin
              pending <= 1'b1;
            end
          end
          ST_WRRUN: begin
            if (acked) pending <= 1'b0;
            else if (!pending && outEmpty && !remainZero) pending <= 1'b1;
            if (lastBitOut && remainZero) begin
              state    <= ST_IDLE;
              irqBlock <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dmaReq    = pending;
  assign dmaWe     = (state == ST_RDRUN);
  assign dmaActive = (state != ST_IDLE);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck && !lenWr |=> dmaReq);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqBlock |-> (state == ST_IDLE));
  // R3
  single_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && lenWr && lenEn && !armed |=> (state == ST_IDLE));
  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (state == ST_IDLE) && !dmaReq);
endmodule

// File: rtl/diskDma.sv
module diskDma
  import diskDmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_HOLD = 2,
  parameter logic [15:0] SYNC_RESET = 16'h4489
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              dmaReq,
  output logic              dmaWe,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [15:0]       dmaWrData,
  input  logic              dmaAck,
  input  logic [15:0]       dmaRdData,
  input  logic              diskBitIn,
  input  logic              diskBitValid,
  output logic              diskBitOut,
  output logic              diskBitOutValid,
  input  logic              diskBitReq,
  output logic              irqSync,
  output logic              irqBlock
);
  ctlStrobe_t ctl;
  logic lenWr, syncHit, wordDone, remainZero, remainOne;
  logic outEmpty, lastBitOut, modeSync, dmaActive;

  assign lenWr = regWr && (regAddr == ADDR_LEN);

  diskControl uCtl (
    .clk(clk), .rstN(rstN),
    .lenWr(lenWr), .lenEn(regWrData[LEN_EN_BIT]), .lenDir(regWrData[LEN_DIR_BIT]),
    .lenCntZero(regWrData[COUNT_W-1:0] == '0),
    .dmaAck(dmaAck), .syncHit(syncHit), .wordDone(wordDone),
    .remainZero(remainZero), .remainOne(remainOne), .outEmpty(outEmpty),
    .lastBitOut(lastBitOut), .modeSync(modeSync), .ctl(ctl),
    .dmaReq(dmaReq), .dmaWe(dmaWe), .dmaActive(dmaActive),
    .irqSync(irqSync), .irqBlock(irqBlock)
  );

  diskDatapath #(.ADDR_W(ADDR_W), .SYNC_HOLD(SYNC_HOLD), .SYNC_RESET(SYNC_RESET)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaActive(dmaActive),
    .dmaRdData(dmaRdData), .diskBitIn(diskBitIn), .diskBitValid(diskBitValid),
    .diskBitReq(diskBitReq), .ctl(ctl), .syncHit(syncHit), .wordDone(wordDone),
    .remainZero(remainZero), .remainOne(remainOne), .outEmpty(outEmpty),
    .lastBitOut(lastBitOut), .modeSync(modeSync), .ptr(dmaAddr), .wordBuf(dmaWrData),
    .diskBitOut(diskBitOut), .diskBitOutValid(diskBitOutValid)
  );
endmodule

// File: tb/tb_diskDma.sv
module tb_diskDma;
  localparam int AW = 16;
  localparam int HOLD = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 0, regRd = 0, dmaAck = 0, diskBitIn = 0, diskBitValid = 0, diskBitReq = 0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0, dmaRdData = '0, regRdData, dmaWrData;
  logic [AW-1:0] dmaAddr;
  logic dmaReq, dmaWe, diskBitOut, diskBitOutValid, irqSync, irqBlock;

  int checks = 0, fails = 0, syncCnt = 0, blkCnt = 0, logN = 0;
  logic [15:0] logAddr [0:63];
  logic [15:0] logData [0:63];
  logic [15:0] st;

  always #5 clk = ~clk;

  diskDma #(.ADDR_W(AW), .SYNC_HOLD(HOLD)) dut (.*);

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] wordPat(input int i);
    case (i % 6)
      0: return 16'hAAAA;  1: return 16'h3333;  2: return 16'hFFFF;
      3: return 16'hF0F0;  4: return 16'h5555;  default: return 16'h0F0F;
    endcase
  endfunction

  function automatic logic [7:0] bytePat(input int i);
    case (i % 7)
      0: return 8'h96;  1: return 8'hA5;  2: return 8'h5A;  3: return 8'hFF;
      4: return 8'h33;  5: return 8'hF0;  default: return 8'h0F;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder and interrupt counters
  always @(negedge clk) begin
    if (irqSync) syncCnt++;
    if (irqBlock) blkCnt++;
    if (dmaAck) dmaAck <= 1'b0;
    else if (dmaReq) begin
      dmaAck <= 1'b1;
      if (dmaWe) begin
        if (logN < 64) begin logAddr[logN] = dmaAddr; logData[logN] = dmaWrData; end
        logN++;
      end else dmaRdData <= memFn(dmaAddr);
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRd = 1; #1 d = regRdData;
    @(negedge clk); regRd = 0;
  endtask

  task automatic sendBit(input logic b, input logic rd);
    @(negedge clk); diskBitIn = b; diskBitValid = 1;
    if (rd) begin regRd = 1; regAddr = 3'd4; end
    @(negedge clk); diskBitValid = 0; regRd = 0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int k = 15; k >= 0; k--) sendBit(w[k], 1'b0);
  endtask

  task automatic pullBit(output logic b);
    int t;
    t = 0;
    @(negedge clk);
    while (!diskBitOutValid && t < 50) begin @(negedge clk); t++; end
    b = diskBitOut; diskBitReq = 1;
    @(negedge clk); diskBitReq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n0, s0;
    logic [15:0] v;
    logic [31:0] got;
    logic b;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset state
    rdReg(3'd4, st); chk("R1 status", st, 16'h0000);
    rdReg(3'd0, v);  chk("R1 ptr", v, 16'h0000);
    chk("R1 idle outputs", {dmaReq, diskBitOutValid, irqSync, irqBlock}, 4'b0000);

    // R1/R7 default sync word detected outside any transfer
    sendWord(16'h4489); idle(1);
    chk("R1 R7 sync pulse", syncCnt, 1);
    rdReg(3'd4, st); chk("R11 sync flag set", st[12], 1'b1);
    v = {bytePat(0), 8'h00};
    sendBit(v[15], 0); sendBit(v[14], 0);
    rdReg(3'd4, st); chk("R11 flag held", st[12], 1'b1);
    sendBit(v[13], 0);
    rdReg(3'd4, st); chk("R11 flag expired", st[12], 1'b0);
    chk("R10 not ready mid byte", st[15], 1'b0);
    for (int k = 12; k >= 9; k--) sendBit(v[k], 0);
    sendBit(v[8], 1'b1);   // R10 status read in the completing cycle
    rdReg(3'd4, st); chk("R10 ready kept on same-cycle read", st[15], 1'b1);
    chk("R10 byte value", st[7:0], bytePat(0));
    rdReg(3'd4, st); chk("R10 ready cleared", st[15], 1'b0);
    for (int i = 1; i < 7; i++) begin
      for (int k = 7; k >= 0; k--) sendBit(bytePat(i)[k], 0);
      rdReg(3'd4, st);
      chk("R10 byte sweep", {st[15], st[7:0]}, {1'b1, bytePat(i)});
    end

    // R2 R3 R5 R8 R12 plain read transfer
    wrReg(3'd0, 16'h1001);
    rdReg(3'd0, v); chk("R2 ptr bit0 forced", v, 16'h1000);
    wrReg(3'd1, 16'h8003); idle(4);
    rdReg(3'd4, st); chk("R3 single write arms only", {st[14], dmaReq}, 2'b00);
    wrReg(3'd1, 16'h8003);
    rdReg(3'd4, st); chk("R12 active read dir", st[14:13], 2'b10);
    n0 = logN;
    for (int w = 0; w < 3; w++) sendWord(wordPat(w));
    idle(4);
    chk("R8 word count", logN - n0, 3);
    for (int w = 0; w < 3; w++)
      chk("R5 word addr/data", {logAddr[n0+w], logData[n0+w]}, {16'h1000 + 16'(2*w), wordPat(w)});
    chk("R8 block irq", blkCnt, 1);
    rdReg(3'd4, st); chk("R12 idle after done", st[14], 1'b0);
    rdReg(3'd0, v);  chk("R2 ptr advanced", v, 16'h1006);
    sendWord(wordPat(3)); idle(3);
    chk("R8 no extra word", logN - n0, 3);

    // R6 R7 sync-waiting read
    wrReg(3'd3, 16'h0400); wrReg(3'd0, 16'h2000);
    wrReg(3'd1, 16'h8002); wrReg(3'd1, 16'h8002);
    n0 = logN; s0 = syncCnt;
    sendWord(16'hAAAA); sendWord(16'h5555); idle(3);
    chk("R6 nothing stored before sync", logN - n0, 0);
    sendWord(16'h4489); idle(1);
    chk("R7 sync pulse during transfer", syncCnt - s0, 1);
    sendWord(wordPat(2)); sendWord(wordPat(3)); idle(4);
    chk("R6 words after sync", logN - n0, 2);
    chk("R6 first word", {logAddr[n0], logData[n0]}, {16'h2000, wordPat(2)});
    chk("R6 second word", {logAddr[n0+1], logData[n0+1]}, {16'h2002, wordPat(3)});
    chk("R8 block irq sync mode", blkCnt, 2);
    wrReg(3'd3, 16'h0000);

    // R4 stop
    wrReg(3'd0, 16'h3000);
    wrReg(3'd1, 16'h8004); wrReg(3'd1, 16'h8004);
    n0 = logN;
    sendWord(wordPat(4)); idle(3);
    chk("R5 first word before stop", {logAddr[n0], logData[n0]}, {16'h3000, wordPat(4)});
    wrReg(3'd1, 16'h0000); idle(2);
    rdReg(3'd4, st); chk("R4 stopped", {st[14], dmaReq}, 2'b00);
    sendWord(wordPat(5)); idle(3);
    chk("R4 no writes after stop", logN - n0, 1);
    wrReg(3'd1, 16'h8004); idle(2);
    rdReg(3'd4, st); chk("R3 stop disarmed", st[14], 1'b0);
    wrReg(3'd1, 16'h0000);

    // R13 zero count
    wrReg(3'd1, 16'h8000); wrReg(3'd1, 16'h8000); idle(4);
    rdReg(3'd4, st); chk("R13 zero count no start", {st[14], dmaReq}, 2'b00);

    // R9 R12 write transfer
    wrReg(3'd0, 16'h4000);
    wrReg(3'd1, 16'hC002); wrReg(3'd1, 16'hC002);
    rdReg(3'd4, st); chk("R12 active write dir", st[14:13], 2'b11);
    got = '0;
    for (int k = 0; k < 32; k++) begin pullBit(b); got = {got[30:0], b}; end
    idle(3);
    chk("R9 serial stream", got, {memFn(16'h4000), memFn(16'h4002)});
    chk("R9 block irq", blkCnt, 3);
    rdReg(3'd4, st); chk("R9 idle after write", {st[14], diskBitOutValid}, 2'b00);
    rdReg(3'd0, v);  chk("R2 ptr after write", v, 16'h4004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule